// File: doc/BRIEF.md
# Aperture Address Remapper

This block translates the addresses of one bus master before they reach a set of target slaves. The top bits of each incoming address pick one of several equal apertures. Each aperture has a programmed target slave number and a replacement value for those same top bits. The remaining lower bits pass through unchanged. With the defaults, the address is 32 bits wide and is split by bits [31:28] into 16 apertures of 256 MB. Each aperture has a 4-bit slave number and a 4-bit replacement nibble.

Software programs shadow tables through a small word-addressed configuration port. The shadow values change nothing until a commit word is written, and then all apertures switch to the new values at once. Translation is combinational from the live tables. The block outputs the chosen slave, the rewritten address and a request strobe. An aperture whose live slave number is zero has no target. A request that falls into such an aperture raises a decode-error flag and issues no request.

Top module: `aperture_remap`

## Requirements
- R1: After reset, every aperture has live and shadow slave number 0 and a replacement nibble equal to its own aperture index. The slave-number words read 0, and the offset words read 0x76543210 at byte address 0x8 and 0xFEDCBA98 at byte address 0xC. A valid request in any aperture raises decErr.
- R2: The aperture index is reqAddr[31:28]. slvAddr is the live replacement nibble of that aperture followed by reqAddr[27:0] unchanged.
- R3: slvSel equals the live slave number of the aperture addressed by reqAddr.
- R4: Slave numbers are written at byte address 0x0 (apertures 0 to 7) and 0x4 (apertures 8 to 15). Replacement nibbles are written at 0x8 (apertures 0 to 7) and 0xC (apertures 8 to 15). Within a word, aperture i occupies bits [4(i mod 8)+3 : 4(i mod 8)].
- R5: Writes to the shadow words at 0x0 to 0xC leave slvSel, slvAddr, slvValid and decErr unchanged until a commit.
- R6: A write with bit 0 set to the commit address 0x10 copies every shadow entry into the live tables. Translation shows the new values from the second rising edge after the write edge, and not earlier. A commit write with bit 0 clear has no effect.
- R7: A read of the commit address 0x10 returns 0.
- R8: A valid request into an aperture whose live slave number is 0 gives decErr=1 and slvValid=0.
- R9: With reqValid low, slvValid and decErr are both 0. With reqValid high, exactly one of them is 1.
- R10: Each shadow word reads back, combinationally through cfgRdData, the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration byte address |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data for cfgAddr |
| reqValid | input | 1 | Master request valid |
| reqAddr | input | 32 | Master address |
| slvValid | output | 1 | Request to the selected slave |
| slvSel | output | 4 | Selected slave number |
| slvAddr | output | 32 | Translated address |
| decErr | output | 1 | Request hit an unmapped aperture |

## Verification
The bench builds the block with its defaults: a 32-bit address, 4-bit aperture fields and 32-bit configuration words. That gives 16 apertures packed eight per word in two register pairs, so both halves of each pair and the word boundary between apertures 7 and 8 are reached. The vector table covers the first and last aperture, mapped and unmapped apertures side by side, and all-ones and all-zeros lower bits. The directed tests cover the cycle where a commit is pending but not yet visible.

// File: rtl/aprm_pkg.sv
package aprm_pkg;
  // Strobes from the control path into the table datapath
  typedef struct packed {
    logic wrSel;   // write shadow slave-number word
    logic wrOff;   // write shadow replacement-nibble word
    logic commit;  // copy shadow into live tables this edge
  } aprm_strb_t;
endpackage

// File: rtl/aprm_ctrl.sv
module aprm_ctrl
  import aprm_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int NREG   = 2,
  parameter int CFG_AW = 5,
  parameter int SLOT_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              updBit,
  input  logic [CFG_W-1:0]  selWord [NREG],
  input  logic [CFG_W-1:0]  offWord [NREG],
  output aprm_strb_t        strb,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [CFG_W-1:0]  cfgRdData
);
  localparam int WIDX_W  = CFG_AW - 2;
  localparam int UPD_IDX = 2 * NREG;

  logic [WIDX_W-1:0] wordIdx;
  logic [WIDX_W-1:0] offIdx;
  logic              isSel;
  logic              isOff;
  logic              isUpd;
  logic              updReg;

  assign wordIdx = cfgAddr[CFG_AW-1:2];
  assign offIdx  = wordIdx - WIDX_W'(NREG);
  assign isSel   = wordIdx < WIDX_W'(NREG);
  assign isOff   = !isSel && (wordIdx < WIDX_W'(2 * NREG));
  assign isUpd   = wordIdx == WIDX_W'(UPD_IDX);

  always_comb begin
    slotIdx = '0;
    if (isSel)      slotIdx = SLOT_W'(wordIdx);
    else if (isOff) slotIdx = SLOT_W'(offIdx);
  end

  // Commit register: self-clearing, acts one cycle after the write
  always_ff @(posedge clk) begin
    if (!rstN) updReg <= 1'b0;
    else       updReg <= cfgWrEn && isUpd && updBit;
  end

  always_comb begin
    strb.wrSel  = cfgWrEn && isSel;
    strb.wrOff  = cfgWrEn && isOff;
    strb.commit = updReg;
  end

  always_comb begin
    cfgRdData = '0;
    if (isSel)      cfgRdData = selWord[slotIdx];
    else if (isOff) cfgRdData = offWord[slotIdx];
  end
endmodule

// File: rtl/aprm_datapath.sv
module aprm_datapath
  import aprm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int AP_BITS = 4,
  parameter int CFG_W   = 32,
  parameter int NREG    = 2,
  parameter int PER_REG = 8,
  parameter int SLOT_W  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  aprm_strb_t         strb,
  input  logic [SLOT_W-1:0]  slotIdx,
  input  logic [CFG_W-1:0]   wrData,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic [CFG_W-1:0]   selWord [NREG],
  output logic [CFG_W-1:0]   offWord [NREG],
  output logic               slvValid,
  output logic [AP_BITS-1:0] slvSel,
  output logic [ADDR_W-1:0]  slvAddr,
  output logic               decErr
);
  localparam int NUM_AP = 1 << AP_BITS;
  localparam int LOW_W  = ADDR_W - AP_BITS;

  logic [AP_BITS-1:0] shSel  [NUM_AP];
  logic [AP_BITS-1:0] shOff  [NUM_AP];
  logic [AP_BITS-1:0] actSel [NUM_AP];
  logic [AP_BITS-1:0] actOff [NUM_AP];

  for (genvar ap = 0; ap < NUM_AP; ap++) begin : g_ap
    localparam int REG = ap / PER_REG;
    localparam int POS = ap % PER_REG;
    logic hitReg;
    assign hitReg = slotIdx == SLOT_W'(REG);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shSel[ap]  <= '0;
        shOff[ap]  <= AP_BITS'(ap);
        actSel[ap] <= '0;
        actOff[ap] <= AP_BITS'(ap);
      end else begin
        if (strb.wrSel && hitReg) shSel[ap] <= wrData[POS*AP_BITS +: AP_BITS];
        if (strb.wrOff && hitReg) shOff[ap] <= wrData[POS*AP_BITS +: AP_BITS];
        if (strb.commit) begin
          actSel[ap] <= shSel[ap];
          actOff[ap] <= shOff[ap];
        end
      end
    end
  end

  // Pack shadow entries back into configuration words
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      selWord[r] = '0;
      offWord[r] = '0;
      for (int p = 0; p < PER_REG; p++) begin
        selWord[r][p*AP_BITS +: AP_BITS] = shSel[r*PER_REG+p];
        offWord[r][p*AP_BITS +: AP_BITS] = shOff[r*PER_REG+p];
      end
    end
  end

  // Combinational translation from the live tables
  logic [AP_BITS-1:0] apIdx;
  logic               mapped;

  assign apIdx    = reqAddr[ADDR_W-1 -: AP_BITS];
  assign slvSel   = actSel[apIdx];
  assign mapped   = slvSel != '0;
  assign slvAddr  = {actOff[apIdx], reqAddr[LOW_W-1:0]};
  assign slvValid = reqValid && mapped;
  assign decErr   = reqValid && !mapped;
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import aprm_pkg::*;
#(
  parameter  int ADDR_W  = 32,
  parameter  int AP_BITS = 4,
  parameter  int CFG_W   = 32,
  localparam int NUM_AP  = 1 << AP_BITS,
  localparam int PER_REG = CFG_W / AP_BITS,
  localparam int NREG    = (NUM_AP + PER_REG - 1) / PER_REG,
  localparam int CFG_AW  = $clog2(2 * NREG + 1) + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic [CFG_W-1:0]   cfgRdData,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               slvValid,
  output logic [AP_BITS-1:0] slvSel,
  output logic [ADDR_W-1:0]  slvAddr,
  output logic               decErr
);
  localparam int SLOT_W = (NREG > 1) ? $clog2(NREG) : 1;

  aprm_strb_t        strb;
  logic [SLOT_W-1:0] slotIdx;
  logic [CFG_W-1:0]  selWord [NREG];
  logic [CFG_W-1:0]  offWord [NREG];

  aprm_ctrl #(
    .CFG_W(CFG_W), .NREG(NREG), .CFG_AW(CFG_AW), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .updBit(cfgWrData[0]), .selWord(selWord), .offWord(offWord),
    .strb(strb), .slotIdx(slotIdx), .cfgRdData(cfgRdData)
  );

  aprm_datapath #(
    .ADDR_W(ADDR_W), .AP_BITS(AP_BITS), .CFG_W(CFG_W),
    .NREG(NREG), .PER_REG(PER_REG), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .slotIdx(slotIdx),
    .wrData(cfgWrData), .reqValid(reqValid), .reqAddr(reqAddr),
    .selWord(selWord), .offWord(offWord), .slvValid(slvValid),
    .slvSel(slvSel), .slvAddr(slvAddr), .decErr(decErr)
  );
endmodule

// File: rtl/aprm_checker.sv
module aprm_checker #(
  parameter int ADDR_W  = 32,
  parameter int AP_BITS = 4,
  parameter int CFG_W   = 32,
  parameter int CFG_AW  = 5,
  parameter int UPD_AD  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic [CFG_AW-1:0]  cfgAddr,
  input logic [CFG_W-1:0]   cfgWrData,
  input logic [CFG_W-1:0]   cfgRdData,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               slvValid,
  input logic [AP_BITS-1:0] slvSel,
  input logic [ADDR_W-1:0]  slvAddr,
  input logic               decErr
);
  localparam int LOW_W = ADDR_W - AP_BITS;
  logic commitWr;
  assign commitWr = cfgWrEn && (cfgAddr == CFG_AW'(UPD_AD)) && cfgWrData[0];

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!slvValid && !decErr)); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (slvValid != decErr)); // R9
  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && slvSel == '0) |-> (decErr && !slvValid)); // R8
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (slvAddr[LOW_W-1:0] == reqAddr[LOW_W-1:0])); // R2
  AST_UPD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == CFG_AW'(UPD_AD)) |-> (cfgRdData == '0)); // R7
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(reqAddr) && $stable(reqValid) && !$past(commitWr, 2))
      |-> ($stable(slvSel) && $stable(slvAddr) && $stable(decErr))); // R5
endmodule

bind aperture_remap aprm_checker #(
  .ADDR_W(ADDR_W), .AP_BITS(AP_BITS), .CFG_W(CFG_W),
  .CFG_AW(CFG_AW), .UPD_AD(8 * NREG)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
  .reqAddr(reqAddr), .slvValid(slvValid), .slvSel(slvSel),
  .slvAddr(slvAddr), .decErr(decErr)
);

// File: tb/tb_aperture_remap.sv
`timescale 1ns/1ps
module tb_aperture_remap;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        slvValid;
  logic [3:0]  slvSel;
  logic [31:0] slvAddr;
  logic        decErr;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aperture_remap dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .slvValid(slvValid), .slvSel(slvSel),
    .slvAddr(slvAddr), .decErr(decErr)
  );

  // {reqAddr, expected slvSel, expected slvAddr, expected decErr}
  localparam int NV = 11;
  localparam logic [68:0] VEC [NV] = '{
    {32'h0123_4567, 4'h1, 32'hF123_4567, 1'b0},
    {32'h1FFF_FFFF, 4'h7, 32'hEFFF_FFFF, 1'b0},
    {32'h2000_0000, 4'h6, 32'hD000_0000, 1'b0},
    {32'h7ABC_DEF0, 4'h1, 32'h8ABC_DEF0, 1'b0},
    {32'h8000_0001, 4'h9, 32'h7000_0001, 1'b0},
    {32'h9000_0000, 4'h0, 32'h6000_0000, 1'b1},
    {32'hA555_AAAA, 4'hD, 32'h5555_AAAA, 1'b0},
    {32'hBFFF_FFFF, 4'h0, 32'h4FFF_FFFF, 1'b1},
    {32'hC000_1000, 4'hE, 32'h3000_1000, 1'b0},
    {32'hEDEA_DBEE, 4'hF, 32'h1DEA_DBEE, 1'b0},
    {32'hF000_0000, 4'h0, 32'h0000_0000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  function automatic logic [31:0] rd(input logic [4:0] a);
    cfgAddr = a;
    return 32'h0;
  endfunction

  task automatic cfgRead(input logic [4:0] a, output logic [31:0] d);
    cfgAddr = a; #0.5; d = cfgRdData;
  endtask

  task automatic probe(input logic [31:0] a);
    reqValid = 1'b1; reqAddr = a; #0.5;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 50000);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    void'(rd(5'h0));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfgRead(5'h00, d); chk("R1 sel word0", d, 32'h0);
    cfgRead(5'h04, d); chk("R1 sel word1", d, 32'h0);
    cfgRead(5'h08, d); chk("R1 off word0", d, 32'h7654_3210);
    cfgRead(5'h0C, d); chk("R1 off word1", d, 32'hFEDC_BA98);
    probe(32'h5000_0000); chk("R1 decErr", {31'h0, decErr}, 32'h1);
    chk("R1 slvValid", {31'h0, slvValid}, 32'h0);

    // R9 idle request
    reqValid = 1'b0; #0.5;
    chk("R9 idle outputs", {30'h0, slvValid, decErr}, 32'h0);

    // R4 R10 program shadow
    cfgWrite(5'h00, 32'h1234_5671);
    cfgWrite(5'h04, 32'h0F0E_0D09);
    cfgWrite(5'h08, 32'h89AB_CDEF);
    cfgWrite(5'h0C, 32'h0123_4567);
    cfgRead(5'h00, d); chk("R10 sel word0", d, 32'h1234_5671);
    cfgRead(5'h04, d); chk("R10 sel word1", d, 32'h0F0E_0D09);
    cfgRead(5'h08, d); chk("R10 off word0", d, 32'h89AB_CDEF);
    cfgRead(5'h0C, d); chk("R10 off word1", d, 32'h0123_4567);

    // R5 shadow has no effect yet
    probe(32'h0123_4567);
    chk("R5 still unmapped", {31'h0, decErr}, 32'h1);
    chk("R5 addr unchanged", slvAddr, 32'h0123_4567);

    // R6 commit with bit0 clear does nothing
    cfgWrite(5'h10, 32'h0000_0002);
    @(negedge clk); #0.5;
    chk("R6 zero commit ignored", {31'h0, decErr}, 32'h1);

    // R7 commit address reads zero
    cfgRead(5'h10, d); chk("R7 update reads 0", d, 32'h0);

    // R6 real commit: not visible one edge after write, visible after two
    cfgWrite(5'h10, 32'h0000_0001);
    #0.5; chk("R6 not yet live", {31'h0, decErr}, 32'h1);
    @(negedge clk); #0.5;
    chk("R6 live after commit", {28'h0, slvSel}, 32'h1);

    // R2 R3 R4 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      probe(VEC[i][68:37]);
      if (VEC[i][0]) begin
        chk("R8 unmapped decErr", {30'h0, decErr, slvValid}, 32'h2);
      end else begin
        chk("R3 slvSel", {28'h0, slvSel}, {28'h0, VEC[i][36:33]});
        chk("R2 slvAddr", slvAddr, VEC[i][32:1]);
        chk("R9 valid outcome", {30'h0, decErr, slvValid}, 32'h1);
      end
    end

    // R6 second commit, upper word only, crossing the aperture 7/8 boundary
    cfgWrite(5'h04, 32'h0000_0000);
    probe(32'h8000_0001);
    chk("R5 upper still mapped", {28'h0, slvSel}, 32'h9);
    cfgWrite(5'h10, 32'h1);
    @(negedge clk); probe(32'h8000_0001);
    chk("R6 upper now unmapped", {31'h0, decErr}, 32'h1);
    probe(32'h7000_0000);
    chk("R4 lower word kept", {28'h0, slvSel}, 32'h1);

    reqValid = 1'b0;
    finishRun();
  end
endmodule